// File: doc/BRIEF.md
# Memory-backed native command port responder

This block stands in for the controller side of a DRAM native application port. A small on-chip word array sits behind it. The array has 2^ADDR_W words of DATA_W bits and is cleared by reset. Requests arrive on a command channel with a valid/ready handshake. Write beats arrive on a separate valid/ready channel. A write beat carries the data and a per-byte mask, and it may arrive before or after its command. The block pairs beats with write commands in order and commits them to the array. Each read command returns one beat after a fixed latency, with a valid strobe and an end flag. Refresh and ZQ request pulses get a delayed one-cycle acknowledge. The block does not model DRAM timing, bank reordering or a physical interface.

Back-pressure rules. `cmd_ready` is a combinational function of the internal state and `cmd_op`. A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. If ready is low, the requester keeps the command on the port and tries again. `wd_ready` depends on state only. A beat is taken only when `wd_valid` and `wd_ready` are both high. The read-return channel has no ready. A beat is presented for exactly one cycle and the consumer must take it.

Top module: `nport_mem_responder`

## Requirements
- R1: After reset release, `init_done` goes high after exactly INIT_CYCLES clock edges. Until then, `cmd_ready` and `wd_ready` are low for every opcode.
- R2: `cmd_ready` is low for every opcode while the pending write commands plus the reads in flight add up to SLOTS or more.
- R3: The read opcode sees `cmd_ready` low while RDQ_CAP reads are in flight. The write opcode is not held back by this condition.
- R4: The write opcode sees `cmd_ready` low while WCQ_DEPTH write commands wait for data. Opcodes other than write are not held back by this condition.
- R5: The block inserts a one-cycle internal read slot in which `cmd_ready` is low. This happens in the cycles where the number of clock edges since reset release, modulo PERIOD, equals PERIOD-1.
- R6: A write beat is taken only when `wd_valid` and `wd_ready` are both high. `wd_ready` is low while WDQ_DEPTH beats are queued without a command.
- R7: Beats that arrive before their command are queued. Beats pair with write commands in the order each was accepted.
- R8: A mask bit of 1 keeps the stored byte unchanged. Mask bit b covers data bits [8b+7:8b], so bit 0 covers the lowest byte. For example, mask 8'h0F keeps bytes 0 to 3.
- R9: A read that is accepted at one clock edge shows `rd_valid` and `rd_last` high together after exactly RD_LAT edges, counting the accepting edge. Each beat is high for one cycle, and beats come out in command order.
- R10: The read opcode sees `cmd_ready` low while any accepted write command is still waiting for its data. A read therefore returns the newest committed data.
- R11: The word index is `cmd_addr[ADDR_LSB+ADDR_W-1:ADDR_LSB]`. The low ADDR_LSB address bits are ignored.
- R12: A pulse on `ref_req` or `zq_req` makes the matching acknowledge go high for one cycle, MAINT_DLY edges after the request edge. `cmd_ready` stays low from the request edge until the acknowledge cycle, inclusive. A request made while the same engine is busy is ignored.
- R13: Opcode 3'b000 is a write and 3'b001 is a read. Any other opcode is accepted under the general ready rules and has no effect.
- R14: During reset, `init_done`, `cmd_ready`, `wd_ready`, `rd_valid`, `rd_last` and both acknowledges are low, and the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | output | 1 | Initialization finished |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_op | input | 3 | Opcode: 000 write, 001 read |
| cmd_addr | input | ADDR_W+ADDR_LSB | Request address |
| wd_valid | input | 1 | Write beat valid |
| wd_ready | output | 1 | Write beat queue has room |
| wd_data | input | DATA_W | Write beat data |
| wd_mask | input | DATA_W/8 | Per-byte keep mask, 1 = keep old byte |
| rd_valid | output | 1 | Read beat valid |
| rd_last | output | 1 | Final beat of the read request |
| rd_data | output | DATA_W | Read beat data |
| ref_req | input | 1 | Refresh request pulse |
| ref_ack | output | 1 | Refresh acknowledge |
| zq_req | input | 1 | ZQ calibration request pulse |
| zq_ack | output | 1 | ZQ acknowledge |

## Verification
The slot-occupancy limit is the hardest state to reach from the ports. It needs reads still inside the latency pipe and a write command with no data, both at once. The stimulus issues two reads back to back. It then sends a bare write command within the RD_LAT window and probes `cmd_ready` under an unused opcode. The periodic slot cannot be controlled directly. The stimulus therefore counts clock edges from reset release and predicts the blocked cycles, both while idle and inside every ready check.

// File: rtl/nport_pkg.sv
package nport_pkg;

  localparam logic [2:0] OP_WRITE = 3'b000;
  localparam logic [2:0] OP_READ  = 3'b001;

  typedef enum logic [1:0] {
    CK_WRITE,
    CK_READ,
    CK_OTHER
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [2:0] op);
    if (op == OP_WRITE)     return CK_WRITE;
    else if (op == OP_READ) return CK_READ;
    else                    return CK_OTHER;
  endfunction

endpackage

// File: rtl/nport_fifo.sv
module nport_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        store[wr_ptr] <= push_data;
        wr_ptr        <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = store[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // R4 and R6: the producer never pushes into a full queue.
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7: pairing pops only queues that hold an entry.
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/nport_rd_pipe.sv
module nport_rd_pipe #(
  parameter int W   = 64,
  parameter int LAT = 6,
  localparam int NW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [W-1:0]  rd_data,
  output logic [NW-1:0] inflight
);

  logic [LAT-1:0] vld;
  logic [W-1:0]   dat [LAT];

  if (LAT == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (!rst_n) vld <= '0;
      else        vld <= load;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (!rst_n) vld <= '0;
      else        vld <= {vld[LAT-2:0], load};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) dat[i] <= '0;
    end else begin
      dat[0] <= load_data;
      for (int i = 1; i < LAT; i++) dat[i] <= dat[i-1];
    end
  end

  always_comb begin
    inflight = '0;
    for (int i = 0; i < LAT; i++) inflight = inflight + NW'(vld[i]);
  end

  assign rd_valid = vld[LAT-1];
  assign rd_data  = dat[LAT-1];
  assign rd_last  = vld[LAT-1];

  // R9: at most one read enters the pipe per cycle.
  p_one_load_per_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= $past(inflight) + 1'b1);

endmodule

// File: rtl/nport_maint.sv
module nport_maint #(
  parameter int DLY = 4,
  localparam int CW = $clog2(DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack,
  output logic busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
    else if (req)             cnt <= CW'(DLY);
  end

  assign ack  = (cnt == CW'(1));
  assign busy = (cnt != '0);

  // R12: the acknowledge lasts a single cycle.
  p_ack_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R12: the engine only becomes busy in response to a request.
  p_busy_from_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));

endmodule

// File: rtl/nport_mem_responder.sv
module nport_mem_responder
  import nport_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 5,
  parameter int ADDR_LSB    = 3,
  parameter int WDQ_DEPTH   = 2,
  parameter int WCQ_DEPTH   = 2,
  parameter int SLOTS       = 3,
  parameter int RD_LAT      = 6,
  parameter int RDQ_CAP     = 2,
  parameter int INIT_CYCLES = 8,
  parameter int PERIOD      = 40,
  parameter int MAINT_DLY   = 4,
  localparam int MASK_W     = DATA_W / 8,
  localparam int CADDR_W    = ADDR_W + ADDR_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               init_done,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [CADDR_W-1:0] cmd_addr,
  input  logic               wd_valid,
  output logic               wd_ready,
  input  logic [DATA_W-1:0]  wd_data,
  input  logic [MASK_W-1:0]  wd_mask,
  output logic               rd_valid,
  output logic               rd_last,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               ref_req,
  output logic               ref_ack,
  input  logic               zq_req,
  output logic               zq_ack
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam int PER_W  = $clog2(PERIOD);
  localparam int INF_W  = $clog2(RD_LAT + 1);
  localparam int WCQ_CW = $clog2(WCQ_DEPTH + 1);
  localparam int WDQ_CW = $clog2(WDQ_DEPTH + 1);
  localparam int SUM_W  = $clog2(WCQ_DEPTH + RD_LAT + SLOTS + 1);
  localparam int BEAT_W = DATA_W + MASK_W;

  // ---------------- initialization ----------------
  logic [INIT_W-1:0] init_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                               init_cnt <= '0;
    else if (init_cnt != INIT_W'(INIT_CYCLES)) init_cnt <= init_cnt + 1'b1;
  end

  assign init_done = (init_cnt == INIT_W'(INIT_CYCLES));

  // ---------------- periodic internal read slot ----------------
  logic [PER_W-1:0] per_cnt;
  logic             per_slot;

  always_ff @(posedge clk) begin
    if (!rst_n)                              per_cnt <= '0;
    else if (per_cnt == PER_W'(PERIOD - 1))  per_cnt <= '0;
    else                                     per_cnt <= per_cnt + 1'b1;
  end

  assign per_slot = (per_cnt == PER_W'(PERIOD - 1));

  // ---------------- refresh / ZQ engines ----------------
  logic [1:0] mreq, mack, mbusy;
  logic       maint_busy;

  assign mreq = {zq_req, ref_req};

  for (genvar g = 0; g < 2; g++) begin : g_maint
    nport_maint #(.DLY(MAINT_DLY)) u_maint (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (mreq[g]),
      .ack  (mack[g]),
      .busy (mbusy[g])
    );
  end

  assign ref_ack    = mack[0];
  assign zq_ack     = mack[1];
  assign maint_busy = |mbusy;

  // ---------------- command decode ----------------
  cmd_kind_e         kind;
  logic [ADDR_W-1:0] cmd_word;
  logic              addr_lsb_unused;
  logic              cmd_fire;

  assign kind            = classify(cmd_op);
  assign cmd_word        = cmd_addr[CADDR_W-1:ADDR_LSB];
  assign addr_lsb_unused = ^cmd_addr;
  assign cmd_fire        = cmd_valid & cmd_ready;

  // ---------------- write beat queue and write command queue ----------------
  logic [BEAT_W-1:0] wdq_head;
  logic              wdq_empty, wdq_full;
  logic [WDQ_CW-1:0] wdq_cnt;
  logic [ADDR_W-1:0] wcq_head;
  logic              wcq_empty, wcq_full;
  logic [WCQ_CW-1:0] wcq_cnt;
  logic              commit;

  assign wd_ready = init_done & ~wdq_full;
  assign commit   = ~wdq_empty & ~wcq_empty;

  nport_fifo #(.W(BEAT_W), .DEPTH(WDQ_DEPTH)) u_wdq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wd_valid & wd_ready),
    .push_data({wd_mask, wd_data}),
    .pop      (commit),
    .head     (wdq_head),
    .empty    (wdq_empty),
    .full     (wdq_full),
    .count    (wdq_cnt)
  );

  nport_fifo #(.W(ADDR_W), .DEPTH(WCQ_DEPTH)) u_wcq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (cmd_fire && kind == CK_WRITE),
    .push_data(cmd_word),
    .pop      (commit),
    .head     (wcq_head),
    .empty    (wcq_empty),
    .full     (wcq_full),
    .count    (wcq_cnt)
  );

  // ---------------- storage ----------------
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] beat_data;
  logic [MASK_W-1:0] beat_mask;

  assign {beat_mask, beat_data} = wdq_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int b = 0; b < MASK_W; b++) begin
        if (!beat_mask[b]) mem[wcq_head][b*8 +: 8] <= beat_data[b*8 +: 8];
      end
    end
  end

  // ---------------- read return pipe ----------------
  logic [INF_W-1:0] rd_inflight;

  nport_rd_pipe #(.W(DATA_W), .LAT(RD_LAT)) u_rd_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_fire && kind == CK_READ),
    .load_data(mem[cmd_word]),
    .rd_valid (rd_valid),
    .rd_last  (rd_last),
    .rd_data  (rd_data),
    .inflight (rd_inflight)
  );

  // ---------------- ready arbitration ----------------
  logic [SUM_W-1:0] occupied;
  logic             slots_full, rd_full, base_ok;

  assign occupied   = SUM_W'(wcq_cnt) + SUM_W'(rd_inflight);
  assign slots_full = (occupied >= SUM_W'(SLOTS));
  assign rd_full    = (rd_inflight >= INF_W'(RDQ_CAP));
  assign base_ok    = init_done & ~per_slot & ~maint_busy & ~slots_full;

  always_comb begin
    unique case (kind)
      CK_READ:  cmd_ready = base_ok & ~rd_full & wcq_empty;
      CK_WRITE: cmd_ready = base_ok & ~wcq_full;
      default:  cmd_ready = base_ok;
    endcase
  end

  // ---------------- assertions ----------------
  p_init_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> init_done);

  p_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (SUM_W'(wcq_cnt) + SUM_W'(rd_inflight) >= SUM_W'(SLOTS)) |-> !cmd_ready);

  p_rd_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inflight <= INF_W'(RDQ_CAP));

  p_wdq_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdq_cnt <= WDQ_CW'(WDQ_DEPTH));

  p_periodic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_cnt == PER_W'(PERIOD - 1)) |-> !cmd_ready);

  p_read_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op == OP_READ) |-> (wcq_cnt == '0));

  p_maint_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mbusy != 2'b00) |-> !cmd_ready);

endmodule

// File: tb/nport_mem_responder_bench.sv
module nport_mem_responder_bench;

  localparam int DATA_W = 64, ADDR_W = 5, ADDR_LSB = 3;
  localparam int RD_LAT = 6, INIT_CYCLES = 8, PERIOD = 40, MAINT_DLY = 4;
  localparam int MASK_W = DATA_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done, cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = 3'b111;
  logic [7:0] cmd_addr = '0;
  logic wd_valid = 1'b0, wd_ready;
  logic [DATA_W-1:0] wd_data = '0;
  logic [MASK_W-1:0] wd_mask = '0;
  logic rd_valid, rd_last;
  logic [DATA_W-1:0] rd_data;
  logic ref_req = 1'b0, ref_ack, zq_req = 1'b0, zq_ack;

  always #10 clk = ~clk;

  nport_mem_responder #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB), .WDQ_DEPTH(2),
    .WCQ_DEPTH(2), .SLOTS(3), .RD_LAT(RD_LAT), .RDQ_CAP(2),
    .INIT_CYCLES(INIT_CYCLES), .PERIOD(PERIOD), .MAINT_DLY(MAINT_DLY)
  ) u_nport_mem_responder (
    .clk(clk), .rst_n(rst_n), .init_done(init_done),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data), .wd_mask(wd_mask),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data),
    .ref_req(ref_req), .ref_ack(ref_ack), .zq_req(zq_req), .zq_ack(zq_ack)
  );

  int n_chk = 0, n_err = 0, ecount = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  function automatic logic per_now();
    return (ecount % PERIOD) == PERIOD - 1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [7:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 3'b111;
  endtask

  task automatic send_data(input logic [63:0] d, input logic [7:0] m);
    @(negedge clk);
    wd_valid = 1'b1; wd_data = d; wd_mask = m;
    #1;
    while (!wd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wd_valid = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [63:0] d, input logic [7:0] m,
                          input logic data_first);
    if (data_first) begin send_data(d, m); send_cmd(3'b000, a); end
    else            begin send_cmd(3'b000, a); send_data(d, m); end
  endtask

  task automatic do_read(input logic [7:0] a, input logic [63:0] exp, input string tag);
    send_cmd(3'b001, a);
    for (int k = 1; k <= RD_LAT; k++) begin
      @(negedge clk);
      if (k == RD_LAT - 1) chk({tag, " R9 early valid"}, 64'(rd_valid), 64'd0);
      if (k == RD_LAT) begin
        chk({tag, " R9 valid"}, 64'(rd_valid), 64'd1);
        chk({tag, " R9 last"}, 64'(rd_last), 64'd1);
        chk({tag, " data"}, rd_data, exp);
      end
    end
  endtask

  typedef struct packed {
    logic        rd;
    logic        dfirst;
    logic [7:0]  addr;
    logic [63:0] data;
    logic [7:0]  mask;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 8'h08, 64'h1111_2222_3333_4444, 8'h00},
    '{1'b0, 1'b0, 8'h10, 64'hAAAA_BBBB_CCCC_DDDD, 8'h00},
    '{1'b1, 1'b0, 8'h08, 64'h1111_2222_3333_4444, 8'h00},
    '{1'b0, 1'b0, 8'h08, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F},
    '{1'b1, 1'b0, 8'h08, 64'hFFFF_FFFF_3333_4444, 8'h00},
    '{1'b1, 1'b0, 8'h13, 64'hAAAA_BBBB_CCCC_DDDD, 8'h00},
    '{1'b0, 1'b1, 8'h10, 64'h0123_4567_89AB_CDEF, 8'hF0},
    '{1'b1, 1'b0, 8'h10, 64'hAAAA_BBBB_89AB_CDEF, 8'h00},
    '{1'b0, 1'b1, 8'hF8, 64'h5A5A_5A5A_5A5A_5A5A, 8'h00},
    '{1'b1, 1'b0, 8'hFF, 64'h5A5A_5A5A_5A5A_5A5A, 8'h00},
    '{1'b1, 1'b0, 8'h00, 64'h0,                   8'h00},
    '{1'b1, 1'b0, 8'h80, 64'h0,                   8'h00}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    int lows, mism, acks;
    // R14 and R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmd_op = 3'b001;
    #1;
    chk("R14 init_done", 64'(init_done), 64'd0);
    chk("R14 ready", 64'({cmd_ready, wd_ready}), 64'd0);
    chk("R14 read out", 64'({rd_valid, rd_last}), 64'd0);
    chk("R14 acks", 64'({ref_ack, zq_ack}), 64'd0);
    rst_n = 1'b1;
    for (int k = 1; k <= INIT_CYCLES; k++) begin
      @(negedge clk); #1;
      if (k == INIT_CYCLES - 1) begin
        chk("R1 init early", 64'(init_done), 64'd0);
        chk("R1 ready before init", 64'({cmd_ready, wd_ready}), 64'd0);
      end
      if (k == INIT_CYCLES) begin
        chk("R1 init done", 64'(init_done), 64'd1);
        chk("R1 cmd ready after init", 64'(cmd_ready), 64'(!per_now()));
        chk("R1 wd ready after init", 64'(wd_ready), 64'd1);
      end
    end
    cmd_op = 3'b111;

    // Table walk: R8, R11, R13 opcodes, R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) do_read(VEC[i].addr, VEC[i].data, $sformatf("R8 R11 vec%0d", i));
      else           do_write(VEC[i].addr, VEC[i].data, VEC[i].mask, VEC[i].dfirst);
    end
    do_read(8'h07, 64'h0, "R14 array cleared");

    // R6 and R7: beats ahead of commands, queue full, in-order pairing
    send_data(64'h4444_0000_0000_0004, 8'h00);
    send_data(64'h5555_0000_0000_0005, 8'h00);
    @(negedge clk); #1;
    chk("R6 wd_ready when queue full", 64'(wd_ready), 64'd0);
    send_cmd(3'b000, 8'h20);
    send_cmd(3'b000, 8'h28);
    do_read(8'h20, 64'h4444_0000_0000_0004, "R7 first pair");
    do_read(8'h28, 64'h5555_0000_0000_0005, "R7 second pair");

    // R4: write command queue full
    send_cmd(3'b000, 8'h30);
    send_cmd(3'b000, 8'h38);
    @(negedge clk);
    cmd_op = 3'b000; #1;
    chk("R4 write blocked", 64'(cmd_ready), 64'd0);
    cmd_op = 3'b111; #1;
    chk("R4 other op free", 64'(cmd_ready), 64'(!per_now()));
    send_data(64'h6666_6666_0000_0006, 8'h00);
    send_data(64'h7777_7777_0000_0007, 8'h00);

    // R3 and R2: reads in flight plus a pending write
    send_cmd(3'b001, 8'h30);
    send_cmd(3'b001, 8'h38);
    cmd_op = 3'b001; #1;
    chk("R3 read blocked at cap", 64'(cmd_ready), 64'd0);
    cmd_op = 3'b000; #1;
    chk("R3 write still allowed", 64'(cmd_ready), 64'(!per_now()));
    send_cmd(3'b000, 8'h40);
    cmd_op = 3'b111; #1;
    chk("R2 slots full", 64'(cmd_ready), 64'd0);
    cmd_op = 3'b111;
    repeat (RD_LAT + 2) @(posedge clk);
    send_data(64'h8888_0000_8888_0008, 8'h00);
    do_read(8'h40, 64'h8888_0000_8888_0008, "R2 drain");

    // R13: other opcode is dropped
    repeat (RD_LAT + 2) @(posedge clk);
    send_cmd(3'b010, 8'h40);
    lows = 0;
    for (int k = 0; k < RD_LAT + 2; k++) begin
      @(negedge clk);
      if (rd_valid) lows++;
    end
    chk("R13 no read beat", 64'(lows), 64'd0);
    do_read(8'h40, 64'h8888_0000_8888_0008, "R13 unchanged");

    // R10: read held while a write waits for data
    send_cmd(3'b000, 8'h48);
    @(negedge clk);
    cmd_op = 3'b001; cmd_addr = 8'h48; #1;
    chk("R10 read held", 64'(cmd_ready), 64'd0);
    cmd_op = 3'b111;
    send_data(64'h9999_9999_9999_9999, 8'h00);
    do_read(8'h48, 64'h9999_9999_9999_9999, "R10 newest");

    // R12: refresh acknowledge timing and ready hold
    repeat (RD_LAT + 2) @(posedge clk);
    @(negedge clk); ref_req = 1'b1;
    @(posedge clk); #1; ref_req = 1'b0;
    for (int k = 1; k <= MAINT_DLY + 1; k++) begin
      @(negedge clk); #1;
      chk($sformatf("R12 ref_ack k=%0d", k), 64'(ref_ack), 64'(k == MAINT_DLY));
      chk($sformatf("R12 ready k=%0d", k), 64'(cmd_ready),
          (k <= MAINT_DLY) ? 64'd0 : 64'(!per_now()));
    end

    // R12: ZQ with a second pulse while busy
    @(negedge clk); zq_req = 1'b1;
    @(posedge clk); #1; zq_req = 1'b0;
    acks = 0;
    for (int k = 1; k <= 3 * MAINT_DLY; k++) begin
      @(negedge clk);
      if (zq_ack) acks++;
      if (k == MAINT_DLY) chk("R12 zq_ack timing", 64'(zq_ack), 64'd1);
      if (k == 2) zq_req = 1'b1;
      if (k == 3) zq_req = 1'b0;
    end
    chk("R12 busy request ignored", 64'(acks), 64'd1);

    // R5: periodic slot while idle
    cmd_op = 3'b111;
    lows = 0; mism = 0;
    for (int k = 0; k < 2 * PERIOD; k++) begin
      @(negedge clk); #1;
      if (!cmd_ready) lows++;
      if (cmd_ready == per_now()) mism++;
    end
    chk("R5 slot count", 64'(lows), 64'd2);
    chk("R5 slot position", 64'(mism), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule